// File: doc/BRIEF.md
# MII Management Frame Register Bridge

This block stands in for a PHY's management channel. Software does not clock bits out on a serial pin. It writes one complete 32-bit management frame into a frame register, and the block performs that frame in the same clock edge. It checks the start code and the PHY address, and it decodes the opcode. It then either stores the data field into a local bank of 16-bit PHY registers or replaces the data field with the addressed register's content. Every frame ends with the low turnaround bit set in the stored frame, so a polling driver sees the frame as finished.

The local PHY bank behaves like a simple transceiver. Setting the soft-reset bit in the control register clears that bit by itself and turns on auto-negotiation. Setting the restart-negotiation bit clears that bit by itself and reports negotiation complete, plus link and partner ability when the link is up. A `link_up` input follows the cable state. Any change on it updates the link bits and raises every bit of a clear-on-read interrupt status register. A 16-bit mask, set to all ones by reset, gates that status onto `irq`. A config register carries two read-only transceiver-present flags.

Top module: `mgmt_frame_bridge`

## Requirements
- R1: The frame register is laid out as start code [31:30], opcode [29:28], PHY address [27:23], register index [22:18], turnaround [17:16] and data [15:0]. If the start code is not 01, the frame is stored as written with bit 16 set, and the PHY bank is untouched.
- R2: A frame whose PHY address differs from PHY_ADDR (default 1) is stored as written with bit 16 set, and the PHY bank is untouched.
- R3: Opcode 01 stores data [15:0] into the indexed PHY register. The frame is stored as written with bit 16 set.
- R4: Opcode 10 stores the frame with bits [31:16] as written, bit 16 set, and [15:0] replaced by the indexed PHY register's content.
- R5: Opcodes 00 and 11 store the frame as written with bit 16 set, and the PHY bank is untouched.
- R6: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: A write to PHY register 0 with bit 9 set stores the value with bit 9 cleared and sets bit 5 of PHY register 1. If the link is up, it also sets bit 2 of PHY register 1 and bit 8 of PHY register 5.
- R8: The config register (word 1) resets to 0x00000100. Bits 9:8 ignore writes, and all other bits are plain storage.
- R9: Reading the interrupt status register (word 3) returns its content and clears it in the same edge.
- R10: The interrupt mask (word 2) resets to 0xFFFF. `irq` is high exactly when some status bit is set whose mask bit is clear.
- R11: One edge after `link_up` changes, bit 2 of PHY register 1 and bit 8 of PHY register 5 equal the new level, and the interrupt status is 0xFFFF.
- R12: After reset, the frame register is 0, and PHY registers 0..5 hold 0x0000, 0x4008 (with bit 2 set if the link is up), PHY_ID_HI, PHY_ID_LO, 0x0100 and 0x0100 (0 if the link is down). The interrupt status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe; data appears on `csr_rdata` after the edge |
| csr_sel | input | 2 | Word select: 0 frame, 1 config, 2 interrupt mask, 3 interrupt status |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| link_up | input | 1 | Current link level |
| irq | output | 1 | Unmasked management interrupt pending |

## Verification
A frame, its PHY-bank side effects and its stored result all take effect in the edge that samples the write strobe. A read strobe loads `csr_rdata` in its edge, and the status clear-on-read happens in that same edge. A `link_up` change shows in the bank and the status after one edge, and `irq` follows the registered status with no further delay. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, so every result is read exactly one edge after its cause.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

   // frame field positions (behavioural: software builds frames with them)
   localparam int FRM_W        = 32;
   localparam int ST_LSB       = 30;
   localparam int OP_LSB       = 28;
   localparam int PA_LSB       = 23;
   localparam int RI_LSB       = 18;
   localparam int TA_LSB       = 16;
   localparam int FIELD_AW     = 5;
   localparam int DATA_W       = 16;

   localparam logic [1:0] START_OK = 2'b01;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;

   // PHY bank register indices
   localparam int PHY_CTRL  = 0;
   localparam int PHY_STAT  = 1;
   localparam int PHY_IDH   = 2;
   localparam int PHY_IDL   = 3;
   localparam int PHY_ADV   = 4;
   localparam int PHY_LPA   = 5;

   // bit positions inside PHY registers
   localparam int CTRL_SRST   = 15;
   localparam int CTRL_ANEN   = 12;
   localparam int CTRL_ANRST  = 9;
   localparam int STAT_100FD  = 14;
   localparam int STAT_ANDONE = 5;
   localparam int STAT_ANABL  = 3;
   localparam int STAT_LINK   = 2;
   localparam int ABIL_100FD  = 8;

   typedef enum logic [1:0] {
      SEL_FRAME = 2'd0,
      SEL_CFG   = 2'd1,
      SEL_IMASK = 2'd2,
      SEL_ISTAT = 2'd3
   } csr_sel_e;

endpackage

// File: rtl/mfb_frame_decode.sv
module mfb_frame_decode
   import mfb_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic [FRM_W-1:0]    frame_in,
   input  logic [DATA_W-1:0]   bank_rdata,
   output logic [FIELD_AW-1:0] bank_idx,
   output logic                bank_we,
   output logic [DATA_W-1:0]   bank_wdata,
   output logic [FRM_W-1:0]    frame_out
);

   logic [1:0]          start_f;
   logic [1:0]          opc_f;
   logic [FIELD_AW-1:0] phy_f;
   logic                accepted;

   assign start_f    = frame_in[ST_LSB +: 2];
   assign opc_f      = frame_in[OP_LSB +: 2];
   assign phy_f      = frame_in[PA_LSB +: FIELD_AW];
   assign bank_idx   = frame_in[RI_LSB +: FIELD_AW];
   assign bank_wdata = frame_in[DATA_W-1:0];
   assign accepted   = (start_f == START_OK) && (phy_f == FIELD_AW'(PHY_ADDR));

   always_comb begin
      frame_out         = frame_in;
      frame_out[TA_LSB] = 1'b1;
      bank_we           = 1'b0;
      if (accepted) begin
         unique case (opc_f)
            OPC_WR:  bank_we = 1'b1;
            OPC_RD:  frame_out[DATA_W-1:0] = bank_rdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mfb_phy_bank.sv
module mfb_phy_bank
   import mfb_pkg::*;
#(
   parameter int          NUM_REGS = 32,
   parameter logic [15:0] ID_HI    = 16'h0A5A,
   parameter logic [15:0] ID_LO    = 16'h3C10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [FIELD_AW-1:0] idx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                link_up,
   output logic [DATA_W-1:0]   rdata,
   output logic                link_evt
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (NUM_REGS < PHY_LPA + 1 || NUM_REGS > (1 << FIELD_AW)) begin : g_bad_depth
      $error("mfb_phy_bank: NUM_REGS out of range");
   end

   function automatic logic [DATA_W-1:0] init_val(int k, logic lnk);
      logic [DATA_W-1:0] v;
      v = '0;
      case (k)
         PHY_STAT: begin
            v[STAT_100FD] = 1'b1;
            v[STAT_ANABL] = 1'b1;
            v[STAT_LINK]  = lnk;
         end
         PHY_IDH: v = ID_HI;
         PHY_IDL: v = ID_LO;
         PHY_ADV: v[ABIL_100FD] = 1'b1;
         PHY_LPA: v[ABIL_100FD] = lnk;
         default: v = '0;
      endcase
      return v;
   endfunction

   logic                           link_q;
   logic                           ctrl_hit;
   logic                           restart;
   logic [DATA_W-1:0]              wr_val;
   logic [NUM_REGS-1:0][DATA_W-1:0] reg_vec;

   always_ff @(posedge clk) begin
      link_q <= link_up;
   end

   assign link_evt = rst_n && (link_up != link_q);
   assign ctrl_hit = we && (idx == FIELD_AW'(PHY_CTRL));
   assign restart  = ctrl_hit && wdata[CTRL_ANRST];

   // self-clearing control bits
   always_comb begin
      wr_val = wdata;
      if (ctrl_hit) begin
         if (wdata[CTRL_SRST]) begin
            wr_val[CTRL_SRST] = 1'b0;
            wr_val[CTRL_ANEN] = 1'b1;
         end
         wr_val[CTRL_ANRST] = 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q_r;
      logic [DATA_W-1:0] d_c;

      if (i == PHY_STAT) begin : g_stat
         always_comb begin
            d_c = q_r;
            if (we && idx == FIELD_AW'(i)) d_c = wr_val;
            if (restart) begin
               d_c[STAT_ANDONE] = 1'b1;
               if (link_q) d_c[STAT_LINK] = 1'b1;
            end
            if (link_evt) d_c[STAT_LINK] = link_up;
         end
      end else if (i == PHY_LPA) begin : g_lpa
         always_comb begin
            d_c = q_r;
            if (we && idx == FIELD_AW'(i)) d_c = wr_val;
            if (restart && link_q) d_c[ABIL_100FD] = 1'b1;
            if (link_evt) d_c[ABIL_100FD] = link_up;
         end
      end else begin : g_plain
         always_comb begin
            d_c = q_r;
            if (we && idx == FIELD_AW'(i)) d_c = wr_val;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= init_val(i, link_up);
         else        q_r <= d_c;
      end

      assign reg_vec[i] = q_r;
   end

   if (NUM_REGS == (1 << FIELD_AW)) begin : g_full_mux
      assign rdata = reg_vec[idx];
   end else begin : g_part_mux
      assign rdata = (32'(idx) < NUM_REGS) ? reg_vec[idx[IDX_W-1:0]] : '0;
   end

   logic [DATA_W-1:0] ctrl_v, stat_v, lpa_v;
   assign ctrl_v = reg_vec[PHY_CTRL];
   assign stat_v = reg_vec[PHY_STAT];
   assign lpa_v  = reg_vec[PHY_LPA];

   assert_ctrl_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (!ctrl_v[CTRL_SRST] && !ctrl_v[CTRL_ANRST]));

   assert_restart_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> stat_v[STAT_ANDONE]);

   assert_link_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> (stat_v[STAT_LINK] == $past(link_up)));

   assert_link_lpa_R11: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> (lpa_v[ABIL_100FD] == $past(link_up)));

endmodule

// File: rtl/mfb_mgmt_csr.sv
module mfb_mgmt_csr
   import mfb_pkg::*;
#(
   parameter int         IRQ_W       = 16,
   parameter int         CFG_RO_LSB  = 8,
   parameter logic [1:0] CFG_RO_INIT = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [1:0]       sel,
   input  logic [FRM_W-1:0] wdata,
   input  logic             link_evt,
   output logic [FRM_W-1:0] cfg_q,
   output logic [IRQ_W-1:0] mask_q,
   output logic [IRQ_W-1:0] stat_q,
   output logic             irq
);

   localparam logic [FRM_W-1:0] RO_MASK  = FRM_W'(2'b11) << CFG_RO_LSB;
   localparam logic [FRM_W-1:0] CFG_INIT = FRM_W'(CFG_RO_INIT) << CFG_RO_LSB;

   if (IRQ_W < 1 || IRQ_W > FRM_W) begin : g_bad_irq_w
      $error("mfb_mgmt_csr: IRQ_W out of range");
   end
   if (CFG_RO_LSB < 0 || CFG_RO_LSB > FRM_W - 2) begin : g_bad_ro
      $error("mfb_mgmt_csr: CFG_RO_LSB out of range");
   end

   logic wr_cfg, wr_mask, wr_stat, rd_stat;
   assign wr_cfg  = wr && (sel == SEL_CFG);
   assign wr_mask = wr && (sel == SEL_IMASK);
   assign wr_stat = wr && (sel == SEL_ISTAT);
   assign rd_stat = rd && (sel == SEL_ISTAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= CFG_INIT;
         mask_q <= '1;
         stat_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= (wdata & ~RO_MASK) | (cfg_q & RO_MASK);
         if (wr_mask) mask_q <= wdata[IRQ_W-1:0];
         if (link_evt)     stat_q <= '1;
         else if (wr_stat) stat_q <= wdata[IRQ_W-1:0];
         else if (rd_stat) stat_q <= '0;
      end
   end

   assign irq = |(stat_q & ~mask_q);

   assert_cfg_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> $stable(cfg_q[CFG_RO_LSB +: 2]));

   assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !wr_stat && !link_evt) |=> (stat_q == '0));

   assert_link_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> (stat_q == '1));

endmodule

// File: rtl/mgmt_frame_bridge.sv
module mgmt_frame_bridge
   import mfb_pkg::*;
#(
   parameter int          PHY_ADDR   = 1,
   parameter int          NUM_REGS   = 32,
   parameter int          IRQ_W      = 16,
   parameter logic [15:0] PHY_ID_HI  = 16'h0A5A,
   parameter logic [15:0] PHY_ID_LO  = 16'h3C10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_wr,
   input  logic        csr_rd,
   input  logic [1:0]  csr_sel,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   input  logic        link_up,
   output logic        irq
);

   if (PHY_ADDR < 0 || PHY_ADDR >= (1 << FIELD_AW)) begin : g_bad_phy
      $error("mgmt_frame_bridge: PHY_ADDR does not fit the address field");
   end

   logic [FIELD_AW-1:0] b_idx;
   logic                b_we_dec;
   logic                b_we;
   logic [DATA_W-1:0]   b_wdata;
   logic [DATA_W-1:0]   b_rdata;
   logic [FRM_W-1:0]    frm_next;
   logic [FRM_W-1:0]    frame_q;
   logic                link_evt;
   logic                frm_wr;
   logic [FRM_W-1:0]    cfg_q;
   logic [IRQ_W-1:0]    mask_q;
   logic [IRQ_W-1:0]    stat_q;

   assign frm_wr = csr_wr && (csr_sel == SEL_FRAME);
   assign b_we   = frm_wr && b_we_dec;

   mfb_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
      .frame_in   (csr_wdata),
      .bank_rdata (b_rdata),
      .bank_idx   (b_idx),
      .bank_we    (b_we_dec),
      .bank_wdata (b_wdata),
      .frame_out  (frm_next)
   );

   mfb_phy_bank #(.NUM_REGS(NUM_REGS), .ID_HI(PHY_ID_HI), .ID_LO(PHY_ID_LO)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (b_we),
      .idx      (b_idx),
      .wdata    (b_wdata),
      .link_up  (link_up),
      .rdata    (b_rdata),
      .link_evt (link_evt)
   );

   mfb_mgmt_csr #(.IRQ_W(IRQ_W)) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (csr_wr),
      .rd       (csr_rd),
      .sel      (csr_sel),
      .wdata    (csr_wdata),
      .link_evt (link_evt),
      .cfg_q    (cfg_q),
      .mask_q   (mask_q),
      .stat_q   (stat_q),
      .irq      (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q   <= '0;
         csr_rdata <= '0;
      end else begin
         if (frm_wr) frame_q <= frm_next;
         if (csr_rd) begin
            unique case (csr_sel)
               SEL_FRAME: csr_rdata <= frame_q;
               SEL_CFG:   csr_rdata <= cfg_q;
               SEL_IMASK: csr_rdata <= FRM_W'(mask_q);
               default:   csr_rdata <= FRM_W'(stat_q);
            endcase
         end
      end
   end

   assert_turnaround_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frm_wr |=> frame_q[TA_LSB]);

   assert_frame_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frm_wr |=> (frame_q[FRM_W-1:TA_LSB+1] == $past(csr_wdata[FRM_W-1:TA_LSB+1])));

endmodule

// File: tb/sim_mgmt_frame_bridge.sv
module sim_mgmt_frame_bridge;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_wr, csr_rd;
   logic [1:0]  csr_sel;
   logic [31:0] csr_wdata;
   logic [31:0] csr_rdata;
   logic        link_up;
   logic        irq;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mgmt_frame_bridge u0 (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
      .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .link_up(link_up), .irq(irq)
   );

   function automatic logic [31:0] mk(logic [1:0] st, logic [1:0] op, logic [4:0] pa,
                                      logic [4:0] ri, logic [1:0] ta, logic [15:0] d);
      return {st, op, pa, ri, ta, d};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      csr_rd = 1'b1; csr_sel = sel;
      @(negedge clk);
      csr_rd = 1'b0;
      d = csr_rdata;
   endtask

   task automatic phy_rd(logic [4:0] ri, output logic [15:0] d);
      logic [31:0] f;
      wr(2'd0, mk(2'b01, 2'b10, 5'd1, ri, 2'b00, 16'h0000));
      rd(2'd0, f);
      d = f[15:0];
   endtask

   task automatic phy_wr(logic [4:0] ri, logic [15:0] d);
      wr(2'd0, mk(2'b01, 2'b01, 5'd1, ri, 2'b00, d));
   endtask

   task automatic t_reset();
      logic [31:0] v; logic [15:0] p;
      rd(2'd0, v); chk("R12 frame reset", v, 32'h0);
      rd(2'd1, v); chk("R8 cfg reset", v, 32'h0000_0100);
      rd(2'd2, v); chk("R10 mask reset", v, 32'h0000_FFFF);
      rd(2'd3, v); chk("R12 istat reset", v, 32'h0);
      chk("R10 irq idle", {31'h0, irq}, 32'h0);
      phy_rd(5'd0, p); chk("R12 ctrl reset", {16'h0, p}, 32'h0000);
      phy_rd(5'd1, p); chk("R12 status reset", {16'h0, p}, 32'h400C);
      phy_rd(5'd2, p); chk("R12 id hi", {16'h0, p}, 32'h0A5A);
      phy_rd(5'd3, p); chk("R12 id lo", {16'h0, p}, 32'h3C10);
      phy_rd(5'd4, p); chk("R12 advert", {16'h0, p}, 32'h0100);
      phy_rd(5'd5, p); chk("R12 partner", {16'h0, p}, 32'h0100);
   endtask

   task automatic t_write_read();
      logic [31:0] f, v;
      f = mk(2'b01, 2'b01, 5'd1, 5'd4, 2'b00, 16'h1234);
      wr(2'd0, f);
      rd(2'd0, v); chk("R3 write frame stored", v, f | 32'h0001_0000);
      f = mk(2'b01, 2'b10, 5'd1, 5'd4, 2'b10, 16'hABCD);
      wr(2'd0, f);
      rd(2'd0, v); chk("R4 read data replaced", v, (f & 32'hFFFF_0000) | 32'h0001_1234);
      phy_wr(5'd31, 16'hBEEF);
      rd(2'd0, v); chk("R3 last register", v, mk(2'b01, 2'b01, 5'd1, 5'd31, 2'b01, 16'hBEEF));
      wr(2'd0, mk(2'b01, 2'b10, 5'd1, 5'd31, 2'b00, 16'h0));
      rd(2'd0, v); chk("R4 last register", v[15:0], 16'hBEEF);
   endtask

   task automatic reject_check(string req, logic [31:0] f);
      logic [31:0] v; logic [15:0] p;
      wr(2'd0, f);
      rd(2'd0, v); chk(req, v, f | 32'h0001_0000);
      phy_rd(5'd4, p); chk(req, {16'h0, p}, 32'h1234);
   endtask

   task automatic t_rejects();
      reject_check("R1 start 00", mk(2'b00, 2'b01, 5'd1, 5'd4, 2'b00, 16'h5555));
      reject_check("R1 start 11", mk(2'b11, 2'b01, 5'd1, 5'd4, 2'b00, 16'h5556));
      reject_check("R2 phy 0",    mk(2'b01, 2'b01, 5'd0, 5'd4, 2'b00, 16'h7777));
      reject_check("R2 phy 2",    mk(2'b01, 2'b01, 5'd2, 5'd4, 2'b00, 16'h7778));
      reject_check("R5 opcode 00", mk(2'b01, 2'b00, 5'd1, 5'd4, 2'b00, 16'h9999));
      reject_check("R5 opcode 11", mk(2'b01, 2'b11, 5'd1, 5'd4, 2'b00, 16'h999A));
   endtask

   task automatic t_ctrl_reset();
      logic [15:0] p;
      phy_wr(5'd0, 16'h8000);
      phy_rd(5'd0, p); chk("R6 reset self-clears", {16'h0, p}, 32'h1000);
      phy_wr(5'd0, 16'h8140);
      phy_rd(5'd0, p); chk("R6 reset keeps others", {16'h0, p}, 32'h1140);
   endtask

   task automatic t_link_restart();
      logic [31:0] v; logic [15:0] p;
      rd(2'd3, v);
      @(negedge clk); link_up = 1'b0;
      @(negedge clk);
      chk("R10 masked irq", {31'h0, irq}, 32'h0);
      phy_rd(5'd1, p); chk("R11 link down status", {16'h0, p}, 32'h4008);
      phy_rd(5'd5, p); chk("R11 link down partner", {16'h0, p}, 32'h0000);
      rd(2'd3, v); chk("R11 istat all ones", v, 32'h0000_FFFF);
      rd(2'd3, v); chk("R9 clear on read", v, 32'h0);
      phy_wr(5'd0, 16'h0200);
      phy_rd(5'd0, p); chk("R7 restart self-clears", {16'h0, p}, 32'h0000);
      phy_rd(5'd1, p); chk("R7 done without link", {16'h0, p}, 32'h4028);
      phy_rd(5'd5, p); chk("R7 no partner without link", {16'h0, p}, 32'h0000);
      @(negedge clk); link_up = 1'b1;
      @(negedge clk);
      phy_rd(5'd1, p); chk("R11 link up status", {16'h0, p}, 32'h402C);
      phy_rd(5'd5, p); chk("R11 link up partner", {16'h0, p}, 32'h0100);
      rd(2'd3, v); chk("R11 istat after up", v, 32'h0000_FFFF);
      phy_wr(5'd1, 16'h4008);
      phy_wr(5'd5, 16'h0000);
      phy_wr(5'd0, 16'h1200);
      phy_rd(5'd0, p); chk("R7 restart with link ctrl", {16'h0, p}, 32'h1000);
      phy_rd(5'd1, p); chk("R7 restart with link status", {16'h0, p}, 32'h402C);
      phy_rd(5'd5, p); chk("R7 restart with link partner", {16'h0, p}, 32'h0100);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      wr(2'd2, 32'h0000_FFFE);
      wr(2'd3, 32'h0000_0001);
      chk("R10 unmasked bit", {31'h0, irq}, 32'h1);
      wr(2'd3, 32'h0000_0002);
      chk("R10 masked bit", {31'h0, irq}, 32'h0);
      wr(2'd2, 32'h0000_FFFD);
      chk("R10 mask change", {31'h0, irq}, 32'h1);
      rd(2'd3, v); chk("R9 read value", v, 32'h0000_0002);
      chk("R9 irq drops after read", {31'h0, irq}, 32'h0);
      rd(2'd3, v); chk("R9 cleared", v, 32'h0);
      wr(2'd2, 32'h0000_FFFF);
   endtask

   task automatic t_cfg();
      logic [31:0] v;
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); chk("R8 ro bits ones", v, 32'hFFFF_FDFF);
      wr(2'd1, 32'h0000_0000);
      rd(2'd1, v); chk("R8 ro bits zero", v, 32'h0000_0100);
   endtask

   initial begin
      rst_n = 1'b0; csr_wr = 1'b0; csr_rd = 1'b0; csr_sel = 2'd0;
      csr_wdata = 32'h0; link_up = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_rejects();
      t_ctrl_reset();
      t_link_restart();
      t_irq();
      t_cfg();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule